// File: doc/BRIEF.md
# Gated Two-Digit Frequency Meter

The block estimates the rate of a fast input clock by counting its rising edges inside a fixed time window. A slow sequencing clock sets that window. A start request launches a measurement cycle. The cycle counts for a set number of sequencing periods, then pauses while the counter settles, and then copies the frozen two-digit decimal result into a display register. Two seven-segment decoders read that register and drive the units digit and the tens digit.

The counter runs entirely on the measured clock. The count-enable reaches it through a two-flop synchronizer, and the counter clears itself on the first edge that sees the enable. The displayed value is therefore one less than the number of measured-clock rising edges that fall inside the enable window, and it stops at 99. If start is still high when the display phase ends, the next measurement follows at once. The count-enable and the display strobe are also brought out as ports so that a test can watch the sequence.

Each decoder blanks its digit for any code from 10 to 15. The counter never produces such a code.

Top module: `freq_meter_top`

## Requirements
- R1: While `rst` is high at rising edges of both clocks, the sequencer returns to idle, the counter clears and the display register clears. Afterwards `count_en` and `disp_strobe` are 0 and both digits show 0.
- R2: In idle, `count_en` stays low while `start` is low. It goes high right after the first `clk_seq` rising edge at which `start` is sampled high.
- R3: `count_en` stays high for exactly `WIN_CYC` `clk_seq` periods (default 16). A display phase of `DISP_CYC` periods (default 3) follows, with `count_en` low. `disp_strobe` is high only in the last period of that phase, for a single period, and never at the same time as `count_en`.
- R4: At the end of the display phase, the block starts a new counting window at once if `start` is sampled high. Otherwise it goes to idle.
- R5: Let N be the number of `clk_meas` rising edges, N ≥ 1, at which `count_en` is high. The value shown after the strobe is N−1 in decimal. The counter does not change while the synchronized enable is low.
- R6: When N−1 exceeds 99, the value shown is 99. The counter holds at 99 and never wraps.
- R7: The display register changes only at a `clk_seq` edge at which `disp_strobe` is high. Measured-clock activity outside a counting window does not change the digits.
- R8: Each segment bus is active high with bit 6 = segment a down to bit 0 = segment g. The lit segments are: 0: a,b,c,d,e,f; 1: b,c; 2: a,b,d,e,g; 3: a,b,c,d,g; 4: b,c,f,g; 5: a,c,d,f,g; 6: a,c,d,e,f,g; 7: a,b,c; 8: all; 9: a,b,c,d,f,g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_seq | input | 1 | Sequencing clock; its periods set the counting window |
| clk_meas | input | 1 | Clock whose frequency is measured |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| start | input | 1 | Measurement request, sampled on `clk_seq` |
| seg_units | output | 7 | Units digit segments {a,b,c,d,e,f,g}, active high |
| seg_tens | output | 7 | Tens digit segments {a,b,c,d,e,f,g}, active high |
| count_en | output | 1 | High during the counting window (sequencing domain) |
| disp_strobe | output | 1 | One-period load pulse for the display register |

## Verification
The two clocks are independent, so an exact expected count is hard to obtain. The bench makes it exact by placing every measured-clock edge 50 ps away from any sequencing-clock edge. It then counts, itself, the measured edges that arrive while `count_en` is high, and the expected value is that count minus one, capped at 99. Reaching saturation takes a measured clock fast enough to give well over a hundred edges per window. Testing back-to-back measurement takes `start` held high across a display phase, so that the second window opens with no idle cycle between the two windows.

// File: rtl/fm_pkg.sv
`timescale 1ns/10ps
package fm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_COUNT = 2'd1,
    SQ_SHOW  = 2'd2
  } sq_state_e;

  // True when a BCD digit has reached its top value.
  function automatic logic digit_is_top(input logic [3:0] d);
    return d == 4'd9;
  endfunction

  // Next value of one BCD digit when it receives a carry.
  function automatic logic [3:0] digit_next(input logic [3:0] d);
    return digit_is_top(d) ? 4'd0 : d + 4'd1;
  endfunction

  // Segment pattern {a,b,c,d,e,f,g}, active high; codes above 9 are blank.
  function automatic logic [6:0] seg_encode(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b0110000;
      4'd2:    s = 7'b1101101;
      4'd3:    s = 7'b1111001;
      4'd4:    s = 7'b0110011;
      4'd5:    s = 7'b1011011;
      4'd6:    s = 7'b1011111;
      4'd7:    s = 7'b1110000;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1111011;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fm_sequencer.sv
`timescale 1ns/10ps
module fm_sequencer #(
  parameter int WIN_CYC  = 16,
  parameter int DISP_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic count_en,
  output logic disp_strobe
);
  import fm_pkg::*;

  localparam int MAXC = (WIN_CYC > DISP_CYC) ? WIN_CYC : DISP_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] DISP_LAST = CW'(DISP_CYC - 1);

  sq_state_e     state_q;
  logic [CW-1:0] cyc_q;
  logic          win_done;
  logic          show_done;

  assign win_done  = (state_q == SQ_COUNT) && (cyc_q == WIN_LAST);
  assign show_done = (state_q == SQ_SHOW)  && (cyc_q == DISP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cyc_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          cyc_q <= '0;
          if (start) state_q <= SQ_COUNT;
        end
        SQ_COUNT: begin
          if (win_done) begin
            state_q <= SQ_SHOW;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        SQ_SHOW: begin
          if (show_done) begin
            state_q <= start ? SQ_COUNT : SQ_IDLE;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: begin
          state_q <= SQ_IDLE;
          cyc_q   <= '0;
        end
      endcase
    end
  end

  assign count_en    = (state_q == SQ_COUNT);
  assign disp_strobe = show_done;

endmodule

// File: rtl/fm_sync.sv
`timescale 1ns/10ps
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d;
        else             chain_q[i] <= chain_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fm_bcd_counter.sv
`timescale 1ns/10ps
module fm_bcd_counter #(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_sync,
  output logic                clr_evt,
  output logic [DIGITS*4-1:0] bcd
);
  import fm_pkg::*;

  logic              en_prev_q;
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] top;
  logic              full;
  logic              step;

  always_ff @(posedge clk) begin
    if (rst) en_prev_q <= 1'b0;
    else     en_prev_q <= en_sync;
  end

  assign clr_evt = en_sync & ~en_prev_q;
  assign full    = &top;
  assign step    = en_sync & en_prev_q & ~full;
  assign carry[0] = step;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [3:0] dig_q;
      assign top[i]       = digit_is_top(dig_q);
      assign carry[i+1]   = carry[i] & top[i];
      assign bcd[i*4 +: 4] = dig_q;
      always_ff @(posedge clk) begin
        if (rst || clr_evt) dig_q <= 4'd0;
        else if (carry[i])  dig_q <= digit_next(dig_q);
      end
    end
  endgenerate

endmodule

// File: rtl/fm_display.sv
`timescale 1ns/10ps
module fm_display #(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [DIGITS*4-1:0] bcd_in,
  output logic [DIGITS*7-1:0] segs
);
  import fm_pkg::*;

  logic [DIGITS*4-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= bcd_in;
  end

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
      assign segs[i*7 +: 7] = seg_encode(held_q[i*4 +: 4]);
    end
  endgenerate

endmodule

// File: rtl/freq_meter_top.sv
`timescale 1ns/10ps
module freq_meter_top #(
  parameter int WIN_CYC     = 16,
  parameter int DISP_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_seq,
  input  logic       clk_meas,
  input  logic       rst,
  input  logic       start,
  output logic [6:0] seg_units,
  output logic [6:0] seg_tens,
  output logic       count_en,
  output logic       disp_strobe
);
  localparam int DIGITS = 2;

  logic                en_meas;
  logic                clr_evt;
  logic [DIGITS*4-1:0] cnt_bcd;
  logic [DIGITS*7-1:0] segs;

  fm_sequencer #(.WIN_CYC(WIN_CYC), .DISP_CYC(DISP_CYC)) u_seq (
    .clk(clk_seq), .rst(rst), .start(start),
    .count_en(count_en), .disp_strobe(disp_strobe)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_meas), .rst(rst), .d(count_en), .q(en_meas)
  );

  fm_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk_meas), .rst(rst), .en_sync(en_meas),
    .clr_evt(clr_evt), .bcd(cnt_bcd)
  );

  fm_display #(.DIGITS(DIGITS)) u_disp (
    .clk(clk_seq), .rst(rst), .load(disp_strobe),
    .bcd_in(cnt_bcd), .segs(segs)
  );

  assign seg_units = segs[6:0];
  assign seg_tens  = segs[13:7];

endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/10ps
module fm_checker (
  input logic       clk_seq,
  input logic       clk_meas,
  input logic       rst,
  input logic       start,
  input logic       count_en,
  input logic       disp_strobe,
  input logic [6:0] seg_units,
  input logic [6:0] seg_tens,
  input logic [7:0] cnt_bcd,
  input logic       clr_evt,
  input logic       en_meas
);

  assert_phase_exclusive_R3: assert property (@(posedge clk_seq) disable iff (rst)
    !(count_en && disp_strobe));

  assert_strobe_single_R3: assert property (@(posedge clk_seq) disable iff (rst)
    disp_strobe |=> !disp_strobe);

  assert_start_needed_R2: assert property (@(posedge clk_seq) disable iff (rst)
    $rose(count_en) |-> $past(start));

  assert_display_hold_R7: assert property (@(posedge clk_seq) disable iff (rst)
    !$past(disp_strobe) |-> $stable({seg_units, seg_tens}));

  assert_clear_on_open_R5: assert property (@(posedge clk_meas) disable iff (rst)
    clr_evt |=> (cnt_bcd == 8'h00));

  assert_frozen_when_off_R5: assert property (@(posedge clk_meas) disable iff (rst)
    !$past(en_meas) |-> $stable(cnt_bcd));

  assert_no_wrap_R6: assert property (@(posedge clk_meas) disable iff (rst)
    ($past(cnt_bcd) == 8'h99 && !$past(clr_evt)) |-> (cnt_bcd == 8'h99));

endmodule

bind freq_meter_top fm_checker u_chk (
  .clk_seq(clk_seq), .clk_meas(clk_meas), .rst(rst), .start(start),
  .count_en(count_en), .disp_strobe(disp_strobe),
  .seg_units(seg_units), .seg_tens(seg_tens),
  .cnt_bcd(cnt_bcd), .clr_evt(clr_evt), .en_meas(en_meas)
);

// File: tb/sim_freq_meter_top.sv
`timescale 1ns/10ps
module sim_freq_meter_top;
  localparam int WIN  = 16;
  localparam int DISP = 3;

  // Digits lighting each segment, index 0 = a ... 6 = g; bit k = digit k.
  localparam logic [9:0] LIT [7] = '{10'h3ED, 10'h39F, 10'h3FB, 10'h36D,
                                     10'h145, 10'h371, 10'h37C};

  typedef struct packed {
    int unsigned per10ps;  // measured clock period in 10 ps units
    bit          sat;      // result must read 99
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{100, 1'b0}, '{290, 1'b0}, '{70, 1'b0},
    '{50, 1'b1},  '{60, 1'b1},  '{390, 1'b0}
  };

  logic clk_seq = 1'b0, clk_meas = 1'b0, rst = 1'b1, start = 1'b0;
  logic [6:0] seg_u, seg_t;
  logic cen, dstb;
  int total = 0, bad = 0, edge_n = 0;
  bit done = 1'b0;
  realtime hp = 0.5;

  freq_meter_top u0 (
    .clk_seq(clk_seq), .clk_meas(clk_meas), .rst(rst), .start(start),
    .seg_units(seg_u), .seg_tens(seg_t), .count_en(cen), .disp_strobe(dstb)
  );

  always #2 clk_seq = ~clk_seq;

  initial begin
    #0.05;
    forever begin
      realtime h;
      h = hp;
      clk_meas = 1'b1; #(h);
      clk_meas = 1'b0; #(h);
    end
  end

  always @(posedge clk_meas) if (cen) edge_n++;

  function automatic logic [6:0] seg_of(input int d);
    logic [6:0] r;
    for (int s = 0; s < 7; s++) r[6-s] = LIT[s][d];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_show(input int v, input string req);
    check(seg_u == seg_of(v % 10), req, "units segments", seg_u, seg_of(v % 10));
    check(seg_t == seg_of(v / 10), req, "tens segments", seg_t, seg_of(v / 10));
  endtask

  task automatic set_period(input int unsigned per10ps);
    hp = real'(per10ps) / 200.0;
    repeat (4) @(negedge clk_seq);
  endtask

  // Runs through one window and display phase; count_en must already be high.
  task automatic window_and_show(input bit sat, input string req, input bit keep);
    int win, d, exp_v, n;
    win = 0;
    while (cen && win < 100) begin
      win++;
      @(negedge clk_seq);
    end
    check(win == WIN, "R3", "window length", win, WIN);
    d = 1;
    while (!dstb && d < 20) begin
      check(!cen, "R3", "enable in display phase", cen, 0);
      @(negedge clk_seq);
      d++;
    end
    check(d == DISP, "R3", "strobe position", d, DISP);
    n = edge_n;
    edge_n = 0;
    if (!keep) start = 1'b0;
    @(negedge clk_seq);
    check(!dstb, "R3", "strobe width", dstb, 0);
    exp_v = (n - 1 > 99) ? 99 : n - 1;
    if (sat) check(exp_v == 99, req, "saturating stimulus", exp_v, 99);
    check_show(exp_v, req);
    check(cen == keep, "R4", "next state after display", cen, keep);
  endtask

  initial begin
    int v15;
    repeat (6) @(negedge clk_seq);
    // R1: reset state
    check(!cen, "R1", "count_en in reset", cen, 0);
    check(!dstb, "R1", "disp_strobe in reset", dstb, 0);
    check_show(0, "R1");
    rst = 1'b0;
    // R2: no start keeps the block idle
    repeat (8) begin
      @(negedge clk_seq);
      check(!cen, "R2", "idle without start", cen, 0);
    end

    // Table walk: R5 / R6 / R8 across measured periods
    foreach (VECS[i]) begin
      set_period(VECS[i].per10ps);
      edge_n = 0;
      start = 1'b1;
      @(negedge clk_seq);
      check(cen, "R2", "count_en after start", cen, 1);
      start = 1'b0;
      window_and_show(VECS[i].sat, VECS[i].sat ? "R6" : "R5", 1'b0);
    end

    // R7: display holds while measured clock changes and no window runs
    v15 = (seg_t == seg_of(1) && seg_u == seg_of(5)) ? 15 : -1;
    set_period(50);
    repeat (30) @(negedge clk_seq);
    check(!cen, "R7", "stays idle", cen, 0);
    if (v15 == 15) check_show(15, "R7");
    else check(0, "R7", "precondition value 15", v15, 15);

    // R4: back-to-back windows with start held high
    set_period(130);
    edge_n = 0;
    start = 1'b1;
    @(negedge clk_seq);
    check(cen, "R2", "count_en after start", cen, 1);
    window_and_show(1'b0, "R5", 1'b1);
    window_and_show(1'b0, "R4", 1'b0);

    // R1: reset in the middle of a window
    start = 1'b1;
    @(negedge clk_seq);
    start = 1'b0;
    repeat (5) @(negedge clk_seq);
    rst = 1'b1;
    repeat (6) @(negedge clk_seq);
    check(!cen, "R1", "count_en after mid reset", cen, 0);
    check(!dstb, "R1", "disp_strobe after mid reset", dstb, 0);
    check_show(0, "R1");
    rst = 1'b0;
    repeat (4) @(negedge clk_seq);
    check(!cen, "R1", "idle after reset release", cen, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule